// File: doc/BRIEF.md
# Glitch-Free Gated Clock Fanout

This block takes two clock sources, a fast system clock and a slower scan or test clock, picks one of them with a select input, gates the chosen clock with a shared enable and drives the result onto a set of identical output channels. Each channel has a true output and its complement. It sits at the root of a small clock tree, where test logic must be able to swap in a slow clock and firmware or power control must be able to stop and restart every branch at once.

The enable is active low and is synchronous. A flop clocked on the falling edge of the selected clock captures it, and that flop gates the clock. Because the flop can only change while the selected clock is low, the gate never opens or closes in the middle of a high phase. Every pulse that reaches an output is a full high phase of the source, and a runt pulse cannot occur. An asynchronous reset forces the gate closed. The number of channels and the depth of the falling-edge capture chain are parameters.

Top module: `gclk_fanout`

## Requirements
- R1: With `src_sel` = 0, the outputs follow the system clock `sys_clk` while the gate is open.
- R2: With `src_sel` = 1, the outputs follow the scan clock `scan_clk` while the gate is open.
- R3: `en_n` acts only through a capture taken at a falling edge of the selected clock. With `SYNC_STAGES` = 1, a level that is present at a falling edge opens (0) or closes (1) the gate for the following high phase. A pulse on `en_n` that begins and ends inside one high phase has no effect on the outputs.
- R4: While the gate is closed, every `q_p` bit is 0.
- R5: On every channel, `q_n` is always the inverse of `q_p`.
- R6: All `N_OUT` channels carry the same value at all times.
- R7: Every high pulse on an output lasts exactly one full high phase of the selected clock. This includes the first pulse after enabling and the last pulse before disabling.
- R8: While `rst_n` is low, the gate is closed at once and the outputs are quiet. After release, no pulse appears until `SYNC_STAGES` falling edges of the selected clock have passed with `en_n` low.
- R9: After `en_n` goes high, the outputs stop within one period of the selected clock and then stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | High-speed system clock source |
| scan_clk | input | 1 | Slow scan or test clock source |
| src_sel | input | 1 | Source select: 0 for the system clock, 1 for the scan clock |
| en_n | input | 1 | Shared enable, active low, captured on a falling edge of the selected clock |
| rst_n | input | 1 | Asynchronous reset, active low; closes the gate |
| q_p | output | N_OUT (4) | True gated clock outputs, one bit per channel |
| q_n | output | N_OUT (4) | Complement gated clock outputs, one bit per channel |

## Verification
The bench toggles `en_n` while the clock is high and while it is low, then measures the width of every output pulse. A gate clocked on the wrong edge, or not registered at all, would show up as short pulses or as an extra or missing cycle. A short low-going `en_n` pulse placed wholly inside one high phase must produce no output pulse, so a design that samples the level asynchronously would leak a runt. The bench also releases reset during a low phase and then changes sources while the gate is closed. Any of three faults would then show up as a mismatch in one of these windows: an output that pulses before the first capture edge, a select that is inverted, or a channel whose true and complement outputs are miswired.

// File: rtl/gclk_fanout_pkg.sv
`timescale 1ns/1ps
package gclk_fanout_pkg;

   // Source selection code carried on the select input
   typedef enum logic {
      SRC_SYS  = 1'b0,
      SRC_SCAN = 1'b1
   } gclk_src_e;

   // Gate state held by the falling-edge capture flop
   typedef enum logic {
      GATE_SHUT = 1'b0,
      GATE_OPEN = 1'b1
   } gclk_gate_e;

endpackage

// File: rtl/gclk_src_mux.sv
`timescale 1ns/1ps
module gclk_src_mux
   import gclk_fanout_pkg::*;
(
   input  logic sys_clk,
   input  logic scan_clk,
   input  logic src_sel,
   output logic sel_clk
);

   gclk_src_e src;

   always_comb begin
      src = gclk_src_e'(src_sel);
      unique case (src)
         SRC_SCAN: sel_clk = scan_clk;
         default:  sel_clk = sys_clk;
      endcase
   end

endmodule

// File: rtl/gclk_en_sync.sv
`timescale 1ns/1ps
module gclk_en_sync
   import gclk_fanout_pkg::*;
#(
   parameter int SYNC_STAGES = 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic en_n,
   output logic gate_en
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_stages
         $error("gclk_en_sync: SYNC_STAGES must be at least 1");
      end

      if (SYNC_STAGES == 1) begin : g_single
         gclk_gate_e st;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) st <= GATE_SHUT;
            else        st <= en_n ? GATE_SHUT : GATE_OPEN;
         end
         assign gate_en = (st == GATE_OPEN);
      end else begin : g_chain
         // every stage is a falling-edge flop, so the last one still
         // only changes while the clock is low
         logic [SYNC_STAGES-1:0] pipe;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[SYNC_STAGES-2:0], ~en_n};
         end
         assign gate_en = pipe[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gclk_gate.sv
`timescale 1ns/1ps
module gclk_gate (
   input  logic clk,
   input  logic gate_en,
   output logic gclk
);

   // gate_en moves only while clk is low, so the AND cannot clip a pulse
   assign gclk = clk & gate_en;

endmodule

// File: rtl/gclk_drive.sv
`timescale 1ns/1ps
module gclk_drive #(
   parameter int N_OUT = 4
)(
   input  logic             gclk,
   output logic [N_OUT-1:0] q_p,
   output logic [N_OUT-1:0] q_n
);

   generate
      if (N_OUT < 1) begin : g_bad_n
         $error("gclk_drive: N_OUT must be at least 1");
      end
      for (genvar ch = 0; ch < N_OUT; ch++) begin : g_ch
         assign q_p[ch] = gclk;
         assign q_n[ch] = ~gclk;
      end
   endgenerate

endmodule

// File: rtl/gclk_fanout.sv
`timescale 1ns/1ps
module gclk_fanout
   import gclk_fanout_pkg::*;
#(
   parameter int N_OUT       = 4,
   parameter int SYNC_STAGES = 1
)(
   input  logic             sys_clk,
   input  logic             scan_clk,
   input  logic             src_sel,
   input  logic             en_n,
   input  logic             rst_n,
   output logic [N_OUT-1:0] q_p,
   output logic [N_OUT-1:0] q_n
);

   localparam int CNT_W = $clog2(SYNC_STAGES + 1) + 1;

   logic sel_clk;
   logic gate_en;
   logic gclk;

   gclk_src_mux u_mux (
      .sys_clk (sys_clk),
      .scan_clk(scan_clk),
      .src_sel (src_sel),
      .sel_clk (sel_clk)
   );

   gclk_en_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (sel_clk),
      .rst_n  (rst_n),
      .en_n   (en_n),
      .gate_en(gate_en)
   );

   gclk_gate u_gate (
      .clk    (sel_clk),
      .gate_en(gate_en),
      .gclk   (gclk)
   );

   gclk_drive #(.N_OUT(N_OUT)) u_drive (
      .gclk(gclk),
      .q_p (q_p),
      .q_n (q_n)
   );

   // ---------------- assertions ----------------
   // gate state seen at the start of each high phase
   logic en_at_rise;
   always_ff @(posedge sel_clk or negedge rst_n) begin
      if (!rst_n) en_at_rise <= 1'b0;
      else        en_at_rise <= gate_en;
   end

   // falling edges seen since reset, saturating
   logic [CNT_W-1:0] fall_cnt;
   always_ff @(negedge sel_clk or negedge rst_n) begin
      if (!rst_n)                            fall_cnt <= '0;
      else if (fall_cnt < CNT_W'(SYNC_STAGES)) fall_cnt <= fall_cnt + 1'b1;
   end

   a_r7_gate_steady_high: assert property (@(negedge sel_clk) disable iff (!rst_n)
      gate_en == en_at_rise);

   a_r8_shut_before_capture: assert property (@(posedge sel_clk) disable iff (!rst_n)
      (fall_cnt < CNT_W'(SYNC_STAGES)) |-> !gate_en);

   a_r4_high_phase_matches_gate: assert property (@(negedge sel_clk) disable iff (!rst_n)
      q_p == {N_OUT{gate_en}});

   a_r5_pair_complement: assert property (@(negedge sel_clk) disable iff (!rst_n)
      q_n == ~q_p);

   a_r1_sys_routed: assert property (@(negedge sys_clk) disable iff (!rst_n)
      (src_sel == SRC_SYS) |-> sel_clk);

   a_r2_scan_routed: assert property (@(negedge scan_clk) disable iff (!rst_n)
      (src_sel == SRC_SCAN) |-> sel_clk);

endmodule

// File: tb/tb_gclk_fanout.sv
`timescale 1ns/1ps
module tb_gclk_fanout;

   localparam int N = 4;

   logic         sys_clk  = 1'b0;
   logic         scan_clk = 1'b0;
   logic         src_sel  = 1'b0;
   logic         en_n     = 1'b0;
   logic         rst_n    = 1'b0;
   logic [N-1:0] q_p;
   logic [N-1:0] q_n;

   int n_vec = 0;
   int n_bad = 0;
   int rise_cnt = 0;

   gclk_fanout #(.N_OUT(N), .SYNC_STAGES(1)) dut (
      .sys_clk (sys_clk),
      .scan_clk(scan_clk),
      .src_sel (src_sel),
      .en_n    (en_n),
      .rst_n   (rst_n),
      .q_p     (q_p),
      .q_n     (q_n)
   );

   always #10 sys_clk  = ~sys_clk;   // 50 MHz
   always #30 scan_clk = ~scan_clk;

   // ---------------- reference model ----------------
   logic m_clk;
   logic m_en = 1'b0;
   always_comb m_clk = src_sel ? scan_clk : sys_clk;
   always @(negedge m_clk or negedge rst_n) begin
      if (!rst_n) m_en <= 1'b0;
      else        m_en <= !en_n;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // mid-phase comparison, never on an edge
   initial begin
      #5;
      forever begin
         logic [N-1:0] e;
         e = (m_clk && m_en && rst_n) ? {N{1'b1}} : '0;
         chk(q_p == e, "R1/R2/R4/R6 q_p", 32'(q_p), 32'(e));
         chk(q_n == ~e, "R5 q_n", 32'(q_n), 32'(~e));
         #10;
      end
   end

   // pulse width monitor on every channel
   for (genvar c = 0; c < N; c++) begin : g_mon
      time t_rise = 0;
      always @(posedge q_p[c]) t_rise = $time;
      always @(negedge q_p[c]) begin
         if (rst_n) begin
            time w;
            time we;
            w  = $time - t_rise;
            we = src_sel ? 30 : 10;
            chk(w == we, "R7 pulse width", 32'(w), 32'(we));
         end
      end
   end
   always @(posedge q_p[0]) rise_cnt++;

   task automatic wait_both_low;
      @(negedge scan_clk);
      #2;
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int rc;
      // R8: reset state
      repeat (3) @(posedge sys_clk);
      #5;
      chk(q_p == '0, "R8 reset q_p", 32'(q_p), 0);
      chk(q_n == '1, "R8 reset q_n", 32'(q_n), 32'hF);
      // release in the low phase: the first high phase stays quiet
      @(negedge sys_clk); #2; rst_n = 1'b1;
      @(posedge sys_clk); #5;
      chk(q_p == '0, "R8 no pulse before first capture", 32'(q_p), 0);
      @(posedge sys_clk); #5;
      chk(q_p == '1, "R1 system clock routed", 32'(q_p), 32'hF);
      repeat (6) @(posedge sys_clk);

      // R9: disable mid-pulse, the running pulse completes
      @(posedge sys_clk); #2; en_n = 1'b1;
      @(posedge sys_clk); #5;
      chk(q_p == '0, "R9 stopped within a cycle", 32'(q_p), 0);
      rc = rise_cnt;
      repeat (3) @(posedge sys_clk);
      #5;
      chk(rise_cnt == rc, "R9 stays stopped", 32'(rise_cnt), 32'(rc));

      // R3: enable pulse inside one high phase is ignored
      @(posedge sys_clk); #2; en_n = 1'b0;
      #5; en_n = 1'b1;
      rc = rise_cnt;
      repeat (3) @(posedge sys_clk);
      #5;
      chk(rise_cnt == rc, "R3 high-phase pulse ignored", 32'(rise_cnt), 32'(rc));

      // R3: enable in the low phase waits for the next falling edge
      @(negedge sys_clk); #2; en_n = 1'b0;
      @(posedge sys_clk); #5;
      chk(q_p == '0, "R3 not yet captured", 32'(q_p), 0);
      @(posedge sys_clk); #5;
      chk(q_p == '1, "R3 captured at falling edge", 32'(q_p), 32'hF);
      @(posedge sys_clk); #2; en_n = 1'b1;
      repeat (2) @(posedge sys_clk);

      // R2: switch to the scan clock while shut and both clocks low
      wait_both_low();
      src_sel = 1'b1;
      en_n    = 1'b0;
      @(posedge scan_clk); #5;
      chk(q_p == '0, "R2 first scan high phase quiet", 32'(q_p), 0);
      @(posedge scan_clk); #5;
      chk(q_p == '1, "R2 scan clock routed", 32'(q_p), 32'hF);
      repeat (4) @(posedge scan_clk);
      @(posedge scan_clk); #2; en_n = 1'b1;
      @(posedge scan_clk); #5;
      chk(q_p == '0, "R9 scan stopped within a cycle", 32'(q_p), 0);
      chk(q_n == '1, "R4 shut q_n high", 32'(q_n), 32'hF);

      // back to the system clock
      wait_both_low();
      src_sel = 1'b0;
      en_n    = 1'b0;
      @(posedge sys_clk); #5;
      chk(q_p == '0, "R1 first high phase after switch quiet", 32'(q_p), 0);
      @(posedge sys_clk); #5;
      chk(q_p == '1, "R1 system clock routed again", 32'(q_p), 32'hF);
      repeat (4) @(posedge sys_clk);

      // R8: asynchronous reset while running
      @(negedge sys_clk); #2; rst_n = 1'b0;
      #1;
      chk(q_p == '0, "R8 reset shuts gate", 32'(q_p), 0);
      repeat (3) @(posedge sys_clk);
      #5;
      chk(q_p == '0, "R8 quiet under reset", 32'(q_p), 0);
      chk(q_n == '1, "R8 complement under reset", 32'(q_n), 32'hF);
      finish_run();
   end

endmodule